// File: doc/BRIEF.md
# Circular Capture Buffer Writer

This block takes a continuous stream of sample words, holds them in a small first-in first-out store, and copies them into a fixed window of external memory. It writes in fixed-length bursts through a simple memory-side port. Each burst has a request phase that carries a start address and a beat count, then a data phase, then a single acknowledge pulse. The window is used as a ring: once the last burst slot near the top of the window is filled, writing carries on from the bottom again.

A second agent reads the same window at the same time, and the writer never waits for it. To let host software keep clear of the writer, the block publishes two values. One is the offset of the next word it will write. The other is a lap count that steps each time the offset wraps. It also reports when the sample store is full, both as a live flag and as a latched flag that software clears.

Top module: `ring_capture_writer`

## Requirements
- R1: A sample is stored only in a cycle where `cap_en` and `smp_valid` are both high and `fifo_full` is low. Samples offered at any other time are dropped. Stored samples reach memory in the order they arrived.
- R2: `mem_req_valid` rises only when `cap_en` was high in the cycle before and at least `BURST_LEN` words were stored. `mem_req_len` equals `BURST_LEN`. The request and its address hold steady until `mem_req_ready` accepts them.
- R3: After a request is accepted, exactly `BURST_LEN` data beats follow. `mem_wlast` is high on the final beat only. A beat holds its data while `mem_wready` is low.
- R4: The request address is `REGION_BASE + wr_ptr`, counted in words. Beat k of a burst goes to that address plus k. No burst reaches past `REGION_BASE + REGION_WORDS - 1`.
- R5: `wr_ptr` grows by `BURST_LEN` in the cycle after `mem_ack` is sampled high. It returns to 0 when it would reach `REGION_WORDS`. It is always a multiple of `BURST_LEN`.
- R6: `lap_cnt` increments in the same update in which `wr_ptr` wraps to 0. It counts modulo 2^`LAP_W`.
- R7: When `cap_en` falls, a burst that has already been requested still completes all its beats and its acknowledge. No new request follows until capture is enabled again.
- R8: A rising edge of `cap_en` clears `wr_ptr` and `lap_cnt` to 0. The clear takes effect at once if no burst is outstanding. Otherwise it takes effect in the cycle after that burst's acknowledge. Stored samples are kept.
- R9: `fifo_full` is high exactly when the store holds `FIFO_DEPTH` words.
- R10: `ovf_sticky` goes high in the cycle after `fifo_full` is seen high. It stays high until `ovf_clr` is sampled high while `fifo_full` is low. If both happen in the same cycle, the set wins.
- R11: After reset, the outputs `mem_req_valid`, `mem_wvalid`, `mem_wlast`, `wr_ptr`, `lap_cnt`, `fifo_full` and `ovf_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_en | input | 1 | Capture enable; a rising edge restarts the ring at offset 0 |
| smp_valid | input | 1 | A sample word is offered this cycle |
| smp_data | input | DATA_W | Sample word |
| mem_req_valid | output | 1 | Burst request pending |
| mem_req_ready | input | 1 | Memory accepts the burst request |
| mem_req_addr | output | ADDR_W | Word address of the first beat |
| mem_req_len | output | clog2(BURST_LEN+1) | Beats in the burst |
| mem_wvalid | output | 1 | Data beat valid |
| mem_wready | input | 1 | Memory accepts the data beat |
| mem_wdata | output | DATA_W | Data beat |
| mem_wlast | output | 1 | Final beat of the burst |
| mem_ack | input | 1 | One-cycle acknowledge that the burst is written |
| wr_ptr | output | clog2(REGION_WORDS) | Offset of the next word to be written |
| lap_cnt | output | LAP_W | Count of completed passes over the window |
| fifo_full | output | 1 | Sample store full (live) |
| ovf_sticky | output | 1 | Latched overflow indication |
| ovf_clr | input | 1 | Clears the latched overflow indication |

## Verification
A wrong stored-sample count shows up in one of two ways: `fifo_full` changes in the wrong cycle, or a request starts one cycle early or late. Either appears at the very next clock edge. A corrupted or mis-ordered store entry shows up as a wrong `mem_wdata` on the first beat that carries it. A slip in the ring offset or the lap count appears on `wr_ptr` and `lap_cnt` in the cycle after the acknowledge, and it also appears on `mem_req_addr` at the next request. A deferred restart that is applied too soon or too late shows as a nonzero `wr_ptr` one cycle after the outstanding acknowledge.

// File: rtl/rcw_pkg.sv
// Shared types for the ring capture writer.
package rcw_pkg;

    // Burst sequencer phases: waiting, request, data beats, acknowledge wait.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2,
        ST_RESP = 2'd3
    } burst_state_t;

endpackage

// File: rtl/rcw_sample_fifo.sv
// Sample store: first-word-fall-through FIFO.
// Assumes DEPTH is a power of two and pop is asserted only when not empty.
// A push offered while full is dropped.
module rcw_sample_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [AW-1:0]     wr_idx;
    logic [AW-1:0]     rd_idx;
    logic              push_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign head    = store[rd_idx];

    // Write an accepted sample into its slot.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[wr_idx] <= push_data;
        end
    end

    // Track the read and write indices and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_idx <= wr_idx + 1'b1;
            if (pop)     rd_idx <= rd_idx + 1'b1;
            case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rcw_burst_engine.sv
// Burst sequencer. It starts a burst when capture is on and a full burst
// of words is stored, runs the request, data and acknowledge phases, and
// turns a rising capture enable into a ring restart that it applies only
// while no burst is outstanding.
// Assumes BURST_LEN >= 2 and that mem_ack arrives only in the wait phase.
module rcw_burst_engine
    import rcw_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             req_ready,
    input  logic             wready,
    input  logic             ack,
    output logic             req_valid,
    output logic             wvalid,
    output logic             wlast,
    output logic             pop,
    output logic             restart_apply,
    output logic             advance
);
    localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0]  NEED      = CNT_W'(BURST_LEN);

    burst_state_t      state;
    logic [BEAT_W-1:0] beat;
    logic              cap_en_q;
    logic              pend_q;
    logic              rise;
    logic              restart_req;
    logic              idle;
    logic              start;

    assign rise          = cap_en && !cap_en_q;
    assign restart_req   = rise || pend_q;
    assign idle          = (state == ST_IDLE);
    assign restart_apply = idle && restart_req;
    assign start         = idle && cap_en && !restart_req && (fifo_count >= NEED);

    assign req_valid = (state == ST_REQ);
    assign wvalid    = (state == ST_DATA);
    assign wlast     = wvalid && (beat == LAST_BEAT);
    assign pop       = wvalid && wready;
    assign advance   = (state == ST_RESP) && ack;

    // Walk the burst phases and count the data beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) state <= ST_REQ;
                ST_REQ: if (req_ready) begin
                    state <= ST_DATA;
                    beat  <= '0;
                end
                ST_DATA: if (wready) begin
                    if (beat == LAST_BEAT) state <= ST_RESP;
                    else                   beat  <= beat + 1'b1;
                end
                ST_RESP: if (ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Remember the enable level and hold a restart until the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_en_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            cap_en_q <= cap_en;
            if (restart_apply) pend_q <= 1'b0;
            else if (rise)     pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rcw_ring_tracker.sv
// Ring position: word offset of the next burst and the lap count.
// Assumes REGION_WORDS is a whole multiple of BURST_LEN, so a burst never
// straddles the top of the window. restart and advance are never high
// together.
module rcw_ring_tracker #(
    parameter int REGION_WORDS = 32,
    parameter int BURST_LEN    = 4,
    parameter int LAP_W        = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            restart,
    input  logic                            advance,
    output logic [$clog2(REGION_WORDS)-1:0] ofs,
    output logic [LAP_W-1:0]                laps
);
    localparam int OFS_W = $clog2(REGION_WORDS);

    logic [OFS_W:0] next_ofs;
    logic           wrap;

    assign next_ofs = {1'b0, ofs} + (OFS_W+1)'(BURST_LEN);
    assign wrap     = (next_ofs == (OFS_W+1)'(REGION_WORDS));

    // Clear on restart; step by one burst, with wrap and lap, on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs  <= '0;
            laps <= '0;
        end else if (restart) begin
            ofs  <= '0;
            laps <= '0;
        end else if (advance) begin
            if (wrap) begin
                ofs  <= '0;
                laps <= laps + 1'b1;
            end else begin
                ofs  <= next_ofs[OFS_W-1:0];
            end
        end
    end
endmodule

// File: rtl/rcw_overflow_latch.sv
// Latched overflow indication. It is set while the sample store is full
// and cleared by software. A set in the same cycle as a clear wins.
module rcw_overflow_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic clr,
    output logic flag
);
    // Set on full, otherwise clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (full) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/ring_capture_writer.sv
// Ring capture writer top level. Incoming samples are stored in a small
// FIFO and written in fixed-length bursts into a memory window that is
// used as a ring. The next write offset and the lap count are published
// so that host software can keep a concurrent reader clear of the writer.
// Assumptions: FIFO_DEPTH is a power of two and at least BURST_LEN;
// REGION_WORDS is a multiple of BURST_LEN; addresses count words.
module ring_capture_writer #(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 16,
    parameter int FIFO_DEPTH   = 16,
    parameter int BURST_LEN    = 4,
    parameter int REGION_BASE  = 256,
    parameter int REGION_WORDS = 32,
    parameter int LAP_W        = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cap_en,
    input  logic                              smp_valid,
    input  logic [DATA_W-1:0]                 smp_data,
    output logic                              mem_req_valid,
    input  logic                              mem_req_ready,
    output logic [ADDR_W-1:0]                 mem_req_addr,
    output logic [$clog2(BURST_LEN+1)-1:0]    mem_req_len,
    output logic                              mem_wvalid,
    input  logic                              mem_wready,
    output logic [DATA_W-1:0]                 mem_wdata,
    output logic                              mem_wlast,
    input  logic                              mem_ack,
    output logic [$clog2(REGION_WORDS)-1:0]   wr_ptr,
    output logic [LAP_W-1:0]                  lap_cnt,
    output logic                              fifo_full,
    output logic                              ovf_sticky,
    input  logic                              ovf_clr
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);
    localparam int LEN_W = $clog2(BURST_LEN+1);

    logic [CNT_W-1:0] fifo_count;
    logic             fifo_pop;
    logic             restart_apply;
    logic             advance;

    assign mem_req_addr = ADDR_W'(REGION_BASE) + ADDR_W'(wr_ptr);
    assign mem_req_len  = LEN_W'(BURST_LEN);

    rcw_sample_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (smp_valid && cap_en),
        .push_data (smp_data),
        .pop       (fifo_pop),
        .head      (mem_wdata),
        .count     (fifo_count),
        .full      (fifo_full)
    );

    rcw_burst_engine #(
        .BURST_LEN (BURST_LEN),
        .CNT_W     (CNT_W)
    ) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_en        (cap_en),
        .fifo_count    (fifo_count),
        .req_ready     (mem_req_ready),
        .wready        (mem_wready),
        .ack           (mem_ack),
        .req_valid     (mem_req_valid),
        .wvalid        (mem_wvalid),
        .wlast         (mem_wlast),
        .pop           (fifo_pop),
        .restart_apply (restart_apply),
        .advance       (advance)
    );

    rcw_ring_tracker #(
        .REGION_WORDS (REGION_WORDS),
        .BURST_LEN    (BURST_LEN),
        .LAP_W        (LAP_W)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_apply),
        .advance (advance),
        .ofs     (wr_ptr),
        .laps    (lap_cnt)
    );

    rcw_overflow_latch u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .full  (fifo_full),
        .clr   (ovf_clr),
        .flag  (ovf_sticky)
    );
endmodule

// File: rtl/rcw_checker.sv
// Protocol and ring checks for ring_capture_writer, attached by bind.
// Sees only the top-level ports.
module rcw_checker #(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 16,
    parameter int BURST_LEN    = 4,
    parameter int REGION_BASE  = 256,
    parameter int REGION_WORDS = 32,
    parameter int LAP_W        = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            cap_en,
    input logic                            mem_req_valid,
    input logic                            mem_req_ready,
    input logic [ADDR_W-1:0]               mem_req_addr,
    input logic                            mem_wvalid,
    input logic                            mem_wready,
    input logic [DATA_W-1:0]               mem_wdata,
    input logic                            mem_wlast,
    input logic                            mem_ack,
    input logic [$clog2(REGION_WORDS)-1:0] wr_ptr,
    input logic [LAP_W-1:0]                lap_cnt,
    input logic                            fifo_full,
    input logic                            ovf_sticky
);
    logic in_window;
    assign in_window = (int'(mem_req_addr) >= REGION_BASE) &&
                       (int'(mem_req_addr) + BURST_LEN <= REGION_BASE + REGION_WORDS);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R2
    req_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(cap_en));

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_wdata));

    // R3
    last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wlast |-> mem_wvalid);

    // R4
    region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> in_window);

    // R5
    ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(wr_ptr) % BURST_LEN) == 0);

    // R5
    ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_ptr) && (wr_ptr != '0) |-> $past(mem_ack));

    // R6
    lap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lap_cnt) && (lap_cnt != '0) |-> $past(mem_ack));

    // R10
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |=> ovf_sticky);
endmodule

bind ring_capture_writer rcw_checker #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .BURST_LEN    (BURST_LEN),
    .REGION_BASE  (REGION_BASE),
    .REGION_WORDS (REGION_WORDS),
    .LAP_W        (LAP_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cap_en        (cap_en),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_wvalid    (mem_wvalid),
    .mem_wready    (mem_wready),
    .mem_wdata     (mem_wdata),
    .mem_wlast     (mem_wlast),
    .mem_ack       (mem_ack),
    .wr_ptr        (wr_ptr),
    .lap_cnt       (lap_cnt),
    .fifo_full     (fifo_full),
    .ovf_sticky    (ovf_sticky)
);

// File: tb/ring_capture_writer_bench.sv
// Bench: behavioural ring-writer model (queue, integers) compared with the
// design on every clock, with a memory responder driving ready and acknowledge.
module ring_capture_writer_bench;
    localparam int DW    = 32;
    localparam int AW    = 16;
    localparam int DEPTH = 16;
    localparam int LEN   = 4;
    localparam int BASE  = 256;
    localparam int WORDS = 32;
    localparam int LAPW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_en = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [2:0]    mem_req_len;
    logic          mem_wvalid;
    logic          mem_wready = 1'b0;
    logic [DW-1:0] mem_wdata;
    logic          mem_wlast;
    logic          mem_ack = 1'b0;
    logic [4:0]    wr_ptr;
    logic [LAPW-1:0] lap_cnt;
    logic          fifo_full;
    logic          ovf_sticky;
    logic          ovf_clr = 1'b0;

    always #5 clk = ~clk;

    ring_capture_writer u_ring_capture_writer (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_len(mem_req_len), .mem_wvalid(mem_wvalid),
        .mem_wready(mem_wready), .mem_wdata(mem_wdata), .mem_wlast(mem_wlast),
        .mem_ack(mem_ack), .wr_ptr(wr_ptr), .lap_cnt(lap_cnt),
        .fifo_full(fifo_full), .ovf_sticky(ovf_sticky), .ovf_clr(ovf_clr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Stimulus controls, applied at the drive point of each step.
    bit cap_cmd = 1'b0;
    bit clr_cmd = 1'b0;
    int smp_pct = 0;
    int rdy_pct = 100;
    int ack_delay = 1;
    logic [DW-1:0] seq = 32'h1000;

    // Reference model state.
    logic [DW-1:0] mq[$];
    int m_ptr = 0, m_lap = 0, m_beats = 0, ack_cnt = 0;
    bit m_req = 0, m_inflight = 0, m_pend = 0, m_sticky = 0, cap_prev = 0;
    bit saw_full = 0, saw_lap_wrap = 0;
    int req_seen = 0;
    int burst_addr = 0;

    task automatic chk(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: compare, drive, then advance the model to the next edge.
    task automatic step();
        bit busy, rise, restart, full_b;
        int cnt_b;
        @(negedge clk);
        chk("R2 req_valid", mem_req_valid, m_req);
        chk("R3 wvalid", mem_wvalid, m_inflight && (m_beats < LEN));
        chk("R5 wr_ptr", wr_ptr, m_ptr);
        chk("R6 lap_cnt", lap_cnt, m_lap);
        chk("R9 fifo_full", fifo_full, mq.size() == DEPTH);
        chk("R10 ovf_sticky", ovf_sticky, m_sticky);
        if (mem_req_valid) begin
            req_seen++;
            chk("R4 req_addr", mem_req_addr, BASE + m_ptr);
            chk("R2 req_len", mem_req_len, LEN);
        end
        if (mem_wvalid) begin
            if (mq.size() == 0) chk("R1 data present", 0, 1);
            else chk("R1 wdata", mem_wdata, mq[0]);
            chk("R3 wlast", mem_wlast, m_beats == LEN - 1);
            chk("R4 beat in window", (burst_addr + m_beats) < BASE + WORDS, 1);
        end
        if (fifo_full) saw_full = 1;
        // drive
        cap_en        = cap_cmd;
        ovf_clr       = clr_cmd;
        smp_valid     = ($urandom_range(99) < smp_pct);
        smp_data      = seq;
        seq           = seq + 1;
        mem_req_ready = ($urandom_range(99) < rdy_pct);
        mem_wready    = ($urandom_range(99) < rdy_pct);
        mem_ack       = (ack_cnt == 1);
        #1;
        // model update for the coming edge
        busy    = mem_req_valid || m_inflight;
        rise    = cap_en && !cap_prev;
        restart = rise || m_pend;
        full_b  = (mq.size() == DEPTH);
        cnt_b   = mq.size();
        if (ack_cnt > 0) ack_cnt--;
        if (mem_wvalid && mem_wready) begin
            void'(mq.pop_front());
            m_beats++;
            if (m_beats == LEN) ack_cnt = ack_delay;
        end
        if (cap_en && smp_valid && !full_b) mq.push_back(smp_data);
        if (mem_ack) begin
            m_inflight = 0;
            m_ptr += LEN;
            if (m_ptr == WORDS) begin
                m_ptr = 0;
                if (m_lap == (1 << LAPW) - 1) saw_lap_wrap = 1;
                m_lap = (m_lap + 1) % (1 << LAPW);
            end
        end
        if (mem_req_valid && mem_req_ready) begin
            m_req = 0; m_inflight = 1; m_beats = 0; burst_addr = BASE + m_ptr;
        end
        if (!busy) begin
            if (restart) begin m_ptr = 0; m_lap = 0; m_pend = 0; end
            else if (cap_en && cnt_b >= LEN) m_req = 1;
        end else if (rise) m_pend = 1;
        if (full_b) m_sticky = 1;
        else if (ovf_clr) m_sticky = 0;
        cap_prev = cap_en;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        @(negedge clk);
        chk("R11 req_valid", mem_req_valid, 0);
        chk("R11 wvalid", mem_wvalid, 0);
        chk("R11 wlast", mem_wlast, 0);
        chk("R11 wr_ptr", wr_ptr, 0);
        chk("R11 lap_cnt", lap_cnt, 0);
        chk("R11 fifo_full", fifo_full, 0);
        chk("R11 ovf_sticky", ovf_sticky, 0);

        // Steady capture with a fast memory: many laps, lap counter wraps.
        cap_cmd = 1; smp_pct = 60; rdy_pct = 100; ack_delay = 1;
        run(1200);
        chk("R6 lap counter wrapped", saw_lap_wrap, 1);

        // Slow memory: store fills, overflow latches, clear while full is ignored.
        smp_pct = 100; rdy_pct = 30; ack_delay = 4;
        run(300);
        chk("R9 store reached full", saw_full, 1);
        clr_cmd = 1; run(3); clr_cmd = 0;
        smp_pct = 0; rdy_pct = 100; ack_delay = 1;
        run(120);
        chk("R10 sticky held", ovf_sticky, 1);
        clr_cmd = 1; run(1); clr_cmd = 0; run(1);
        chk("R10 sticky cleared", ovf_sticky, 0);

        // R7: drop enable with a burst requested; it completes, nothing new starts.
        smp_pct = 100; rdy_pct = 50;
        while (!mem_req_valid) step();
        cap_cmd = 0;
        run(40);
        req_seen = 0;
        run(40);
        chk("R7 no request while off", req_seen, 0);
        chk("R7 burst finished", m_inflight, 0);

        // R8: restart while idle clears at once; samples offered while off were dropped (R1).
        cap_cmd = 1; smp_pct = 70;
        run(2);
        chk("R8 ptr cleared", wr_ptr, 0);
        chk("R8 lap cleared", lap_cnt, 0);
        run(200);

        // R8: restart while a burst is outstanding waits for its acknowledge.
        rdy_pct = 20; smp_pct = 100;
        while (!m_inflight) step();
        cap_cmd = 0; run(1); cap_cmd = 1; run(1);
        while (m_inflight) step();
        run(2);
        chk("R8 deferred clear", wr_ptr, 0);
        rdy_pct = 100; smp_pct = 50;
        run(300);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule